// File: doc/BRIEF.md
# Snooping Three-State Coherence Controller

This block keeps one small direct-mapped cache coherent with its neighbours on a shared, atomic snooping bus. Each line carries a tag, one data word and a state that is Invalid, Shared (clean, others may hold copies) or Exclusive (the only copy, writable, possibly newer than memory). The processor side presents a held request with address, direction and write data. It sees a stall until the request can be served from the cache, and read data in the cycle the stall is low.

When a request cannot be served locally, the controller raises a bus request. After the grant it drives a read-miss, write-miss or writeback transaction, and it keeps that transaction on the bus until the completion strobe. At the same time it watches every transaction another cache drives. It supplies its own data when it owns the block in Exclusive, then downgrades or invalidates the line. Main memory and the arbiter sit outside the block.

Top module: `snoop_coh_ctrl`

## Requirements
- R1: After reset every line is Invalid, so the first access to any address issues a bus transaction.
- R2: A processor read that hits a Shared or Exclusive line returns the stored word with the stall low and issues no bus transaction.
- R3: A processor read to an Invalid or absent line issues a read miss (command code 1) for that address and leaves the line Shared with the word supplied on the bus.
- R4: A miss whose indexed line holds a different tag in Exclusive first issues a writeback (command code 3) of the old address and word, then the miss; a different tag in Shared issues only the miss.
- R5: A processor write that hits an Exclusive line updates the word locally with no bus transaction.
- R6: A processor write to a Shared, Invalid or absent line issues a write miss (command code 2), and the line ends Exclusive holding the written word.
- R7: A snooped read miss matching an Exclusive line makes this cache raise its flush output with the line's word, and the line drops to Shared. A snooped read miss on a Shared line leaves it unchanged.
- R8: A snooped write miss invalidates a matching line; when the line was Exclusive its word is flushed first.
- R9: The bus request stays high, and command, address and data stay stable, from grant until the completion cycle. Only one transaction is outstanding at a time.
- R10: When a snooped transaction updates the cache in the same cycle as a pending processor request, the snoop is applied and the processor request stalls that cycle.
- R11: Across caches a single writer holds a block at a time, and every read returns the most recently written value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cpu_req | input | 1 | Processor request, held until accepted |
| cpu_we | input | 1 | 1 = write, 0 = read |
| cpu_addr | input | AW | Word address |
| cpu_wdata | input | DW | Write data |
| cpu_rdata | output | DW | Read data, valid when the request is accepted |
| cpu_stall | output | 1 | High while a held request cannot complete |
| bus_req | output | 1 | Request for the shared bus |
| bus_gnt | input | 1 | Grant to this cache, held through completion |
| bus_done | input | 1 | Completion strobe of the transaction on the bus |
| bus_cmd_o | output | 2 | Own command: 0 none, 1 read miss, 2 write miss, 3 writeback |
| bus_addr_o | output | AW | Own transaction address |
| bus_data_o | output | DW | Own writeback word |
| bus_cmd | input | 2 | Command currently on the shared bus |
| bus_addr | input | AW | Address currently on the shared bus |
| bus_rdata | input | DW | Word returned on the bus in the completion cycle |
| snp_flush | output | 1 | This cache supplies the word for a snooped miss |
| snp_data | output | DW | Word supplied with snp_flush |

## Verification
The contested cycle is the one where a neighbour's write miss on a block this cache holds in Exclusive completes. In that same cycle, the local processor presents a write to the same block that would otherwise hit. The bench waits for the completion strobe of the neighbour's transaction and raises the local write at that moment. It expects the stall to be high in that cycle, then a fresh write miss from this cache. Afterwards both caches must read back the locally written word, which shows that the snoop was applied first and the later write was ordered after it.

// File: rtl/coh_pkg.sv
package coh_pkg;
  typedef enum logic [1:0] {
    ST_I = 2'd0,
    ST_S = 2'd1,
    ST_E = 2'd2
  } line_st_e;

  typedef enum logic [1:0] {
    CMD_NONE = 2'd0,
    CMD_RD   = 2'd1,
    CMD_WR   = 2'd2,
    CMD_WB   = 2'd3
  } bus_cmd_e;

  // a foreign miss changes a matching line when it writes, or reads an owned line
  function automatic logic snoop_touches(line_st_e st, bus_cmd_e c);
    return (c == CMD_WR) || (c == CMD_RD && st == ST_E);
  endfunction

  function automatic line_st_e snoop_next(line_st_e st, bus_cmd_e c);
    if (c == CMD_WR) return ST_I;
    if (c == CMD_RD && st == ST_E) return ST_S;
    return st;
  endfunction

  function automatic logic snoop_supplies(line_st_e st, bus_cmd_e c);
    return (st == ST_E) && (c == CMD_RD || c == CMD_WR);
  endfunction

  // state a line takes when this cache's own transaction completes
  function automatic line_st_e fill_state(bus_cmd_e c);
    case (c)
      CMD_WR:  return ST_E;
      CMD_RD:  return ST_S;
      default: return ST_I;
    endcase
  endfunction
endpackage

// File: rtl/coh_line_store.sv
module coh_line_store
  import coh_pkg::*;
#(
  parameter int IW = 2,
  parameter int TW = 6,
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [IW-1:0] cpu_idx,
  input  logic [IW-1:0] snp_idx,
  input  logic          wr_en,
  input  logic [IW-1:0] wr_idx,
  input  logic [TW-1:0] wr_tag,
  input  line_st_e      wr_st,
  input  logic [DW-1:0] wr_data,
  output logic [TW-1:0] cpu_tag,
  output line_st_e      cpu_st,
  output logic [DW-1:0] cpu_data,
  output logic [TW-1:0] snp_tag,
  output line_st_e      snp_st,
  output logic [DW-1:0] snp_data
);
  localparam int LINES = 1 << IW;

  line_st_e      st_q   [LINES];
  logic [TW-1:0] tag_q  [LINES];
  logic [DW-1:0] data_q [LINES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < LINES; i++) begin
        st_q[i]   <= ST_I;
        tag_q[i]  <= '0;
        data_q[i] <= '0;
      end
    end else if (wr_en) begin
      st_q[wr_idx]   <= wr_st;
      tag_q[wr_idx]  <= wr_tag;
      data_q[wr_idx] <= wr_data;
    end
  end

  assign cpu_tag  = tag_q[cpu_idx];
  assign cpu_st   = st_q[cpu_idx];
  assign cpu_data = data_q[cpu_idx];
  assign snp_tag  = tag_q[snp_idx];
  assign snp_st   = st_q[snp_idx];
  assign snp_data = data_q[snp_idx];
endmodule

// File: rtl/coh_snoop.sv
module coh_snoop
  import coh_pkg::*;
#(
  parameter int AW = 8,
  parameter int IW = 2
) (
  input  logic [1:0]       bus_cmd,
  input  logic [AW-1:0]    bus_addr,
  input  logic             bus_gnt,
  input  logic             bus_done,
  input  logic [AW-IW-1:0] line_tag,
  input  line_st_e         line_st,
  output logic [IW-1:0]    snp_idx,
  output logic             snp_flush,
  output logic             snp_apply,
  output line_st_e         snp_next_st
);
  localparam int TW = AW - IW;

  bus_cmd_e      cmd;
  logic          foreign;
  logic          match;
  logic [TW-1:0] addr_tag;

  assign cmd      = bus_cmd_e'(bus_cmd);
  assign snp_idx  = bus_addr[IW-1:0];
  assign addr_tag = bus_addr[AW-1:IW];
  assign foreign  = !bus_gnt && (cmd != CMD_NONE);
  assign match    = foreign && (line_st != ST_I) && (line_tag == addr_tag);

  assign snp_flush   = match && snoop_supplies(line_st, cmd);
  assign snp_apply   = match && bus_done && snoop_touches(line_st, cmd);
  assign snp_next_st = snoop_next(line_st, cmd);
endmodule

// File: rtl/coh_bus_fsm.sv
module coh_bus_fsm
  import coh_pkg::*;
#(
  parameter int AW = 8,
  parameter int IW = 2,
  parameter int DW = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cpu_req,
  input  logic             cpu_we,
  input  logic [AW-1:0]    cpu_addr,
  input  logic [DW-1:0]    cpu_wdata,
  input  logic             cpu_go,
  input  logic [AW-IW-1:0] line_tag,
  input  line_st_e         line_st,
  input  logic [DW-1:0]    line_data,
  input  logic             snp_apply,
  input  logic [IW-1:0]    snp_idx,
  input  logic             bus_gnt,
  input  logic             bus_done,
  input  logic [DW-1:0]    bus_rdata,
  output logic             bus_req,
  output logic [1:0]       bus_cmd_o,
  output logic [AW-1:0]    bus_addr_o,
  output logic [DW-1:0]    bus_data_o,
  output logic             fill_en,
  output logic [IW-1:0]    fill_idx,
  output logic [AW-IW-1:0] fill_tag,
  output line_st_e         fill_st,
  output logic [DW-1:0]    fill_data
);
  typedef enum logic {F_IDLE, F_BUSY} fsm_e;

  fsm_e          fsm_q;
  bus_cmd_e      cmd_q;
  logic [AW-1:0] addr_q;
  logic [DW-1:0] data_q;

  logic start;
  logic need_wb;
  logic own_done;
  logic victim_gone;

  assign start    = (fsm_q == F_IDLE) && cpu_req && !snp_apply && !cpu_go;
  assign need_wb  = (line_st == ST_E) && (line_tag != cpu_addr[AW-1:IW]);
  assign own_done = (fsm_q == F_BUSY) && bus_gnt && bus_done;
  // a pending writeback becomes pointless once a snoop takes the victim away
  assign victim_gone = (fsm_q == F_BUSY) && !bus_gnt && (cmd_q == CMD_WB) &&
                       snp_apply && (snp_idx == addr_q[IW-1:0]);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fsm_q  <= F_IDLE;
      cmd_q  <= CMD_NONE;
      addr_q <= '0;
      data_q <= '0;
    end else if (start) begin
      fsm_q <= F_BUSY;
      if (need_wb) begin
        cmd_q  <= CMD_WB;
        addr_q <= {line_tag, cpu_addr[IW-1:0]};
        data_q <= line_data;
      end else begin
        cmd_q  <= cpu_we ? CMD_WR : CMD_RD;
        addr_q <= cpu_addr;
        data_q <= cpu_wdata;
      end
    end else if (own_done || victim_gone) begin
      fsm_q <= F_IDLE;
      cmd_q <= CMD_NONE;
    end
  end

  assign bus_req    = (fsm_q == F_BUSY);
  assign bus_cmd_o  = cmd_q;
  assign bus_addr_o = addr_q;
  assign bus_data_o = data_q;

  assign fill_en   = own_done;
  assign fill_idx  = addr_q[IW-1:0];
  assign fill_tag  = addr_q[AW-1:IW];
  assign fill_st   = fill_state(cmd_q);
  assign fill_data = (cmd_q == CMD_WB) ? data_q : bus_rdata;

  // R9
  gnt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_gnt && !bus_done) |=> (bus_req && $stable(bus_cmd_o) &&
                                $stable(bus_addr_o) && $stable(bus_data_o)));

  // R9
  gnt_has_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_gnt && bus_done) |-> bus_req);
endmodule

// File: rtl/snoop_coh_ctrl.sv
module snoop_coh_ctrl
  import coh_pkg::*;
#(
  parameter int AW = 8,
  parameter int IW = 2,
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cpu_req,
  input  logic          cpu_we,
  input  logic [AW-1:0] cpu_addr,
  input  logic [DW-1:0] cpu_wdata,
  output logic [DW-1:0] cpu_rdata,
  output logic          cpu_stall,
  output logic          bus_req,
  input  logic          bus_gnt,
  input  logic          bus_done,
  output logic [1:0]    bus_cmd_o,
  output logic [AW-1:0] bus_addr_o,
  output logic [DW-1:0] bus_data_o,
  input  logic [1:0]    bus_cmd,
  input  logic [AW-1:0] bus_addr,
  input  logic [DW-1:0] bus_rdata,
  output logic          snp_flush,
  output logic [DW-1:0] snp_data
);
  localparam int TW = AW - IW;

  logic [IW-1:0] cpu_idx;
  logic [TW-1:0] cpu_tag_in;
  logic [TW-1:0] line_tag;
  line_st_e      line_st;
  logic [DW-1:0] line_data;
  logic [TW-1:0] s_tag;
  line_st_e      s_st;
  logic [DW-1:0] s_data;

  logic          snp_apply;
  logic [IW-1:0] snp_idx;
  line_st_e      snp_next_st;

  logic          fill_en;
  logic [IW-1:0] fill_idx;
  logic [TW-1:0] fill_tag;
  line_st_e      fill_st;
  logic [DW-1:0] fill_data;

  logic          wr_en;
  logic [IW-1:0] wr_idx;
  logic [TW-1:0] wr_tag;
  line_st_e      wr_st;
  logic [DW-1:0] wr_data;

  logic hit;
  logic cpu_go;
  logic own_wb_done;

  assign cpu_idx    = cpu_addr[IW-1:0];
  assign cpu_tag_in = cpu_addr[AW-1:IW];

  coh_line_store #(.IW(IW), .TW(TW), .DW(DW)) u_store (
    .clk      (clk),
    .rst_n    (rst_n),
    .cpu_idx  (cpu_idx),
    .snp_idx  (snp_idx),
    .wr_en    (wr_en),
    .wr_idx   (wr_idx),
    .wr_tag   (wr_tag),
    .wr_st    (wr_st),
    .wr_data  (wr_data),
    .cpu_tag  (line_tag),
    .cpu_st   (line_st),
    .cpu_data (line_data),
    .snp_tag  (s_tag),
    .snp_st   (s_st),
    .snp_data (s_data)
  );

  coh_snoop #(.AW(AW), .IW(IW)) u_snoop (
    .bus_cmd     (bus_cmd),
    .bus_addr    (bus_addr),
    .bus_gnt     (bus_gnt),
    .bus_done    (bus_done),
    .line_tag    (s_tag),
    .line_st     (s_st),
    .snp_idx     (snp_idx),
    .snp_flush   (snp_flush),
    .snp_apply   (snp_apply),
    .snp_next_st (snp_next_st)
  );

  assign snp_data = s_data;

  // local service: present, and writable when writing
  assign hit    = (line_st != ST_I) && (line_tag == cpu_tag_in);
  assign cpu_go = cpu_req && !bus_req && !snp_apply && hit &&
                  (!cpu_we || line_st == ST_E);
  assign cpu_stall = cpu_req && !cpu_go;
  assign cpu_rdata = line_data;

  coh_bus_fsm #(.AW(AW), .IW(IW), .DW(DW)) u_fsm (
    .clk        (clk),
    .rst_n      (rst_n),
    .cpu_req    (cpu_req),
    .cpu_we     (cpu_we),
    .cpu_addr   (cpu_addr),
    .cpu_wdata  (cpu_wdata),
    .cpu_go     (cpu_go),
    .line_tag   (line_tag),
    .line_st    (line_st),
    .line_data  (line_data),
    .snp_apply  (snp_apply),
    .snp_idx    (snp_idx),
    .bus_gnt    (bus_gnt),
    .bus_done   (bus_done),
    .bus_rdata  (bus_rdata),
    .bus_req    (bus_req),
    .bus_cmd_o  (bus_cmd_o),
    .bus_addr_o (bus_addr_o),
    .bus_data_o (bus_data_o),
    .fill_en    (fill_en),
    .fill_idx   (fill_idx),
    .fill_tag   (fill_tag),
    .fill_st    (fill_st),
    .fill_data  (fill_data)
  );

  // one writer per cycle: snoop first, then own completion, then local write
  always_comb begin
    wr_en   = 1'b0;
    wr_idx  = cpu_idx;
    wr_tag  = line_tag;
    wr_st   = line_st;
    wr_data = line_data;
    if (snp_apply) begin
      wr_en   = 1'b1;
      wr_idx  = snp_idx;
      wr_tag  = s_tag;
      wr_st   = snp_next_st;
      wr_data = s_data;
    end else if (fill_en) begin
      wr_en   = 1'b1;
      wr_idx  = fill_idx;
      wr_tag  = fill_tag;
      wr_st   = fill_st;
      wr_data = fill_data;
    end else if (cpu_go && cpu_we) begin
      wr_en   = 1'b1;
      wr_idx  = cpu_idx;
      wr_tag  = cpu_tag_in;
      wr_st   = ST_E;
      wr_data = cpu_wdata;
    end
  end

  assign own_wb_done = bus_gnt && bus_done && (bus_cmd_e'(bus_cmd_o) == CMD_WB);

  // R10
  snoop_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (snp_apply && cpu_req) |-> cpu_stall);

  // R2
  hit_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_req && !cpu_stall) |-> !bus_req);

  // R4
  wb_then_miss_chk: assert property (@(posedge clk) disable iff (!rst_n)
    own_wb_done |=> (!cpu_req || cpu_stall));

  // R7
  flush_not_own_chk: assert property (@(posedge clk) disable iff (!rst_n)
    snp_flush |-> !bus_gnt);
endmodule

// File: tb/snoop_coh_ctrl_tb.sv
module snoop_coh_ctrl_tb;
  localparam int AW = 8;
  localparam int IW = 2;
  localparam int DW = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #4 clk = ~clk;

  logic          c_req   [2];
  logic          c_we    [2];
  logic [AW-1:0] c_addr  [2];
  logic [DW-1:0] c_wd    [2];
  logic [DW-1:0] c_rd    [2];
  logic          c_stall [2];
  logic          m_req   [2];
  logic [1:0]    m_cmd   [2];
  logic [AW-1:0] m_addr  [2];
  logic [DW-1:0] m_data  [2];
  logic          m_flush [2];
  logic [DW-1:0] m_fdata [2];
  logic          gnt     [2];

  logic          busy;
  logic          own;
  logic          rr;
  logic [1:0]    cnt;
  logic          bus_done;
  logic [1:0]    bus_cmd;
  logic [AW-1:0] bus_addr;
  logic [DW-1:0] bus_rdata;
  logic [DW-1:0] mem [1 << AW];

  int n_chk = 0;
  int n_bad = 0;
  int ntx [2];
  logic [1:0]    lcmd  [2][64];
  logic [AW-1:0] laddr [2][64];
  logic [DW-1:0] ldata [2][64];
  int stab_err = 0;

  assign bus_done  = busy && (cnt == 2'd2);
  assign gnt[0]    = busy && !own;
  assign gnt[1]    = busy && own;
  assign bus_cmd   = busy ? (own ? m_cmd[1] : m_cmd[0]) : 2'd0;
  assign bus_addr  = own ? m_addr[1] : m_addr[0];
  assign bus_rdata = m_flush[0] ? m_fdata[0] : m_flush[1] ? m_fdata[1] : mem[bus_addr];

  snoop_coh_ctrl #(.AW(AW), .IW(IW), .DW(DW)) u_dut (
    .clk(clk), .rst_n(rst_n),
    .cpu_req(c_req[0]), .cpu_we(c_we[0]), .cpu_addr(c_addr[0]), .cpu_wdata(c_wd[0]),
    .cpu_rdata(c_rd[0]), .cpu_stall(c_stall[0]),
    .bus_req(m_req[0]), .bus_gnt(gnt[0]), .bus_done(bus_done),
    .bus_cmd_o(m_cmd[0]), .bus_addr_o(m_addr[0]), .bus_data_o(m_data[0]),
    .bus_cmd(bus_cmd), .bus_addr(bus_addr), .bus_rdata(bus_rdata),
    .snp_flush(m_flush[0]), .snp_data(m_fdata[0])
  );

  snoop_coh_ctrl #(.AW(AW), .IW(IW), .DW(DW)) u_peer (
    .clk(clk), .rst_n(rst_n),
    .cpu_req(c_req[1]), .cpu_we(c_we[1]), .cpu_addr(c_addr[1]), .cpu_wdata(c_wd[1]),
    .cpu_rdata(c_rd[1]), .cpu_stall(c_stall[1]),
    .bus_req(m_req[1]), .bus_gnt(gnt[1]), .bus_done(bus_done),
    .bus_cmd_o(m_cmd[1]), .bus_addr_o(m_addr[1]), .bus_data_o(m_data[1]),
    .bus_cmd(bus_cmd), .bus_addr(bus_addr), .bus_rdata(bus_rdata),
    .snp_flush(m_flush[1]), .snp_data(m_fdata[1])
  );

  // arbiter, memory and transaction log
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy <= 1'b0; own <= 1'b0; rr <= 1'b0; cnt <= '0;
      for (int i = 0; i < (1 << AW); i++) mem[i] <= {8'hC0, i[7:0]};
      ntx[0] <= 0; ntx[1] <= 0;
    end else if (busy) begin
      if (bus_done) begin
        busy <= 1'b0;
        if (bus_cmd == 2'd3) mem[bus_addr] <= own ? m_data[1] : m_data[0];
        else if (m_flush[0] || m_flush[1]) mem[bus_addr] <= bus_rdata;
        lcmd[own][ntx[own] % 64]  <= bus_cmd;
        laddr[own][ntx[own] % 64] <= bus_addr;
        ldata[own][ntx[own] % 64] <= own ? m_data[1] : m_data[0];
        ntx[own] <= ntx[own] + 1;
      end else cnt <= cnt + 2'd1;
    end else if (m_req[0] || m_req[1]) begin
      busy <= 1'b1;
      cnt  <= '0;
      own  <= (m_req[0] && (!m_req[1] || !rr)) ? 1'b0 : 1'b1;
      rr   <= ~rr;
    end
  end

  // R9: granted transaction stays put from grant to completion
  logic [1:0]    p_cmd;
  logic [AW-1:0] p_addr;
  logic [DW-1:0] p_data;
  always @(negedge clk) begin
    if (busy && cnt != 2'd0 &&
        (bus_cmd != p_cmd || bus_addr != p_addr ||
         (own ? m_data[1] : m_data[0]) != p_data || !(own ? m_req[1] : m_req[0])))
      stab_err++;
    p_cmd  <= bus_cmd;
    p_addr <= bus_addr;
    p_data <= own ? m_data[1] : m_data[0];
  end

  task automatic check(input string req, input string what, input logic [31:0] act,
                       input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic op_now(input int m, input bit we, input logic [AW-1:0] a,
                        input logic [DW-1:0] wd, output logic [DW-1:0] rd,
                        output int nt, output int first);
    first = ntx[m];
    c_req[m] = 1'b1; c_we[m] = we; c_addr[m] = a; c_wd[m] = wd;
    #1;
    while (c_stall[m]) begin
      @(negedge clk);
      #1;
    end
    rd = c_rd[m];
    @(posedge clk);
    #1;
    c_req[m] = 1'b0;
    nt = ntx[m] - first;
  endtask

  task automatic op(input int m, input bit we, input logic [AW-1:0] a,
                    input logic [DW-1:0] wd, output logic [DW-1:0] rd,
                    output int nt, output int first);
    @(negedge clk);
    op_now(m, we, a, wd, rd, nt, first);
  endtask

  logic [DW-1:0] rd;
  int nt, f0;

  task automatic t_reset_and_fill();
    check("R1", "stall at rest", {31'd0, c_stall[0]}, 32'd0);
    check("R1", "no request at rest", {31'd0, m_req[0]}, 32'd0);
    op(0, 0, 8'h10, 16'h0, rd, nt, f0);
    check("R1", "first read goes to bus", nt, 1);
    check("R3", "read miss command", lcmd[0][f0 % 64], 2'd1);
    check("R3", "read miss address", laddr[0][f0 % 64], 8'h10);
    check("R3", "read miss data", rd, 16'hC010);
  endtask

  task automatic t_read_hit();
    op(0, 0, 8'h10, 16'h0, rd, nt, f0);
    check("R2", "hit issues nothing", nt, 0);
    check("R2", "hit data", rd, 16'hC010);
  endtask

  task automatic t_write_paths();
    op(0, 1, 8'h10, 16'hAAAA, rd, nt, f0);
    check("R6", "write on Shared is one bus txn", nt, 1);
    check("R6", "write miss command", lcmd[0][f0 % 64], 2'd2);
    op(0, 1, 8'h10, 16'hBBBB, rd, nt, f0);
    check("R5", "write hit on Exclusive is local", nt, 0);
    op(0, 0, 8'h10, 16'h0, rd, nt, f0);
    check("R5", "local write readback", rd, 16'hBBBB);
  endtask

  task automatic t_victims();
    op(0, 0, 8'h14, 16'h0, rd, nt, f0);
    check("R4", "Exclusive victim gives two txns", nt, 2);
    check("R4", "writeback first", lcmd[0][f0 % 64], 2'd3);
    check("R4", "writeback address", laddr[0][f0 % 64], 8'h10);
    check("R4", "writeback data", ldata[0][f0 % 64], 16'hBBBB);
    check("R4", "then read miss", lcmd[0][(f0 + 1) % 64], 2'd1);
    check("R4", "new line data", rd, 16'hC014);
    op(1, 0, 8'h10, 16'h0, rd, nt, f0);
    check("R11", "written-back word visible to peer", rd, 16'hBBBB);
    op(0, 0, 8'h18, 16'h0, rd, nt, f0);
    check("R4", "Shared victim gives one txn", nt, 1);
    check("R4", "no writeback for Shared victim", lcmd[0][f0 % 64], 2'd1);
  endtask

  task automatic t_snoop_read();
    op(0, 1, 8'h21, 16'h1234, rd, nt, f0);
    op(0, 1, 8'h21, 16'h1235, rd, nt, f0);
    check("R5", "second write local", nt, 0);
    op(1, 0, 8'h21, 16'h0, rd, nt, f0);
    check("R7", "owner supplies word", rd, 16'h1235);
    op(0, 0, 8'h21, 16'h0, rd, nt, f0);
    check("R7", "owner keeps copy after downgrade", nt, 0);
    op(0, 1, 8'h21, 16'h5678, rd, nt, f0);
    check("R7", "downgraded line needs write miss", nt, 1);
  endtask

  task automatic t_snoop_write();
    op(1, 1, 8'h21, 16'h9999, rd, nt, f0);
    check("R8", "peer write miss", nt, 1);
    op(0, 0, 8'h21, 16'h0, rd, nt, f0);
    check("R8", "Exclusive invalidated by snooped write", nt, 1);
    check("R11", "latest value after invalidation", rd, 16'h9999);
    op(1, 1, 8'h21, 16'h7777, rd, nt, f0);
    op(0, 0, 8'h21, 16'h0, rd, nt, f0);
    check("R8", "Shared invalidated by snooped write", nt, 1);
    check("R11", "latest value from peer", rd, 16'h7777);
    op(1, 0, 8'h18, 16'h0, rd, nt, f0);
    op(0, 0, 8'h18, 16'h0, rd, nt, f0);
    check("R7", "snooped read leaves Shared line", nt, 0);
  endtask

  task automatic t_same_cycle();
    logic [DW-1:0] prd;
    int pnt, pf;
    op(0, 1, 8'h31, 16'h0101, rd, nt, f0);
    fork
      op(1, 1, 8'h31, 16'h0202, prd, pnt, pf);
      begin
        @(negedge clk);
        while (!(bus_done && gnt[1])) @(negedge clk);
        c_req[0] = 1'b1; c_we[0] = 1'b1; c_addr[0] = 8'h31; c_wd[0] = 16'h0011;
        #1;
        check("R10", "stall while snoop applies", {31'd0, c_stall[0]}, 32'd1);
        op_now(0, 1, 8'h31, 16'h0011, rd, nt, f0);
        check("R10", "write reissued as miss", nt, 1);
      end
    join
    check("R10", "peer write one txn", pnt, 1);
    op(0, 0, 8'h31, 16'h0, rd, nt, f0);
    check("R11", "local read after race", rd, 16'h0011);
    op(1, 0, 8'h31, 16'h0, rd, nt, f0);
    check("R11", "peer read after race", rd, 16'h0011);
  endtask

  initial begin
    for (int m = 0; m < 2; m++) begin
      c_req[m] = 1'b0; c_we[m] = 1'b0; c_addr[m] = '0; c_wd[m] = '0;
    end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    t_reset_and_fill();
    t_read_hit();
    t_write_paths();
    t_victims();
    t_snoop_read();
    t_snoop_write();
    t_same_cycle();
    repeat (4) @(negedge clk);
    check("R9", "transaction stability violations", stab_err, 0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: actual hung expected finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule